// File: doc/BRIEF.md
# Lamp Ballast Mode Sequencer

This block is the digital controller of a half-bridge fluorescent lamp ballast. It takes digitised comparator flags for the supply, the DC bus, a lamp-presence shutdown line, die temperature and the half-bridge current sense. It walks the ballast through a wait-for-power state, a filament preheat interval, an ignition sweep and steady running. Hazardous conditions drop it into a latched fault state, and a lamp exchange or a supply collapse brings it back to the start of the sequence.

A counter clocked by a strobe from the oscillator (`osc_tick_i`, one pulse per oscillator period) stands in for the analog preheat timing capacitor. The ignition interval reuses the same counter and is fixed at one quarter of the preheat length. The block drives a frequency selector (class and numeric code) for the analog oscillator, a bridge enable, and the enables of the over-current and under-current checks. The analog oscillator, the comparators and the gate drivers sit outside the block.

Top module: `ballast_sequencer`

## Requirements
- R1: After reset, `mode_o` reads 0 (wait-for-power), `bridge_en_o`, `oc_chk_en_o` and `uc_chk_en_o` are 0, `fsel_o` is 0 and `fcode_o` is CODE_START. Mode encoding: 0 wait-for-power, 1 preheat, 2 ignition, 3 run, 4 fault.
- R2: Wait-for-power moves to preheat only when supply-above-turn-on, bus OK, shutdown low and no overtemperature all hold together. If any one of them is missing, the block stays put.
- R3: In preheat, ignition or run, a supply below the turn-off level, a low bus or a high shutdown line returns the block to wait-for-power. This takes priority over any fault flag raised in the same cycle.
- R4: The timer counts oscillator ticks from zero in preheat and ignition. Preheat ends on the first clock edge at which the timer holds PH_COUNT. Ignition ends on the first edge at which it holds PH_COUNT + PH_COUNT/4. With a tick every clock, preheat is visible for PH_COUNT+1 cycles and ignition for PH_COUNT/4 cycles.
- R5: In preheat, both current checks are masked and current flags have no effect. The over-current check is enabled in ignition and run. The under-current check is enabled in run only.
- R6: Overtemperature in any active mode, over-current in ignition or run, and under-current in run each enter fault.
- R7: In wait-for-power and fault, the bridge is off and the timer is held at zero, so every restart begins with the start frequency phase.
- R8: Fault is latched and survives removal of its cause. It clears to wait-for-power only on a high-then-low pulse of the shutdown line, or on the supply falling below the turn-off level.
- R9: `fsel_o` encoding: 0 start, 1 preheat, 2 ignition/minimum, 3 run. In preheat, the selector is start with code CODE_START while the timer is below START_CYCLES, and preheat with code CODE_PH afterwards.
- R10: In ignition, `fsel_o` is 2. `fcode_o` starts at CODE_PH and drops by one every RAMP_DIV ticks, saturating at CODE_MIN.
- R11: In run, a set `run_strap_i` gives selector 3 with CODE_RUN. A clear strap gives selector 2 with CODE_MIN.
- R12: Every comparator flag passes through a two-flop synchroniser. A flag change driven before a clock edge alters `mode_o` at the third edge, not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_on_i | input | 1 | Supply above turn-on threshold |
| vcc_off_i | input | 1 | Supply below turn-off threshold |
| bus_ok_i | input | 1 | DC bus above its restart level |
| sd_hi_i | input | 1 | Shutdown / lamp-removed line high |
| otemp_i | input | 1 | Die overtemperature |
| ocur_i | input | 1 | Bridge current above over-current level |
| ucur_i | input | 1 | Bridge current below under-current level |
| osc_tick_i | input | 1 | One pulse per oscillator period, synchronous |
| run_strap_i | input | 1 | Select distinct run frequency |
| mode_o | output | 3 | Current mode |
| bridge_en_o | output | 1 | Half-bridge switching enabled |
| oc_chk_en_o | output | 1 | Over-current check enabled |
| uc_chk_en_o | output | 1 | Under-current check enabled |
| fsel_o | output | 2 | Frequency selector class |
| fcode_o | output | CODE_W | Frequency code for the oscillator |

## Verification
A timer that failed to clear in the idle states would show at restart as a short or missing start phase, with `fsel_o` leaving 0 early in the first preheat cycles. A timer miscount would move the preheat-to-ignition or ignition-to-run edge by whole cycles, and that edge is checked on its exact cycle. A lost or stuck fault-release flag appears as `mode_o` leaving 4 either without the shutdown pulse or never, within three cycles of the shutdown line falling. Mis-staged check enables appear on `oc_chk_en_o`/`uc_chk_en_o` in the same cycle as the mode change, and as a spurious fault from flags held during preheat.

// File: rtl/ballast_pkg.sv
package ballast_pkg;

  typedef enum logic [2:0] {
    MD_UVLO    = 3'd0,
    MD_PREHEAT = 3'd1,
    MD_IGNITE  = 3'd2,
    MD_RUN     = 3'd3,
    MD_FAULT   = 3'd4
  } mode_t;

  typedef enum logic [1:0] {
    FS_START   = 2'd0,
    FS_PREHEAT = 2'd1,
    FS_IGNITE  = 2'd2,
    FS_RUN     = 2'd3
  } fsel_t;

  // Flag vector positions inside the synchroniser bank.
  localparam int FL_VCC_ON  = 0;
  localparam int FL_VCC_OFF = 1;
  localparam int FL_BUS_OK  = 2;
  localparam int FL_SD      = 3;
  localparam int FL_OTEMP   = 4;
  localparam int FL_OCUR    = 5;
  localparam int FL_UCUR    = 6;
  localparam int FLAG_N     = 7;

  // Safe values while reset is held: supply reported low, everything else quiet.
  localparam logic [FLAG_N-1:0] FLAG_RST = 7'b000_0010;

  function automatic logic is_active(mode_t m);
    return (m == MD_PREHEAT) || (m == MD_IGNITE) || (m == MD_RUN);
  endfunction

endpackage

// File: rtl/ballast_flag_sync.sv
module ballast_flag_sync #(
  parameter int               WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= RST_VAL[i];
        s2_q <= RST_VAL[i];
      end else begin
        s1_q <= d_i[i];
        s2_q <= s1_q;
      end
    end
    assign q_o[i] = s2_q;
  end

endmodule

// File: rtl/ballast_phase_timer.sv
module ballast_phase_timer #(
  parameter int LIMIT = 50,
  parameter int W     = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         run_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = clr_i || (run_i && tick_i && (cnt_q != W'(LIMIT)));

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  AST_TIMER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));  // R7
  AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && run_i && tick_i && (cnt_q != W'(LIMIT))) |=> (cnt_q == $past(cnt_q) + W'(1)));  // R4
  AST_TIMER_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= W'(LIMIT));  // R4

endmodule

// File: rtl/ballast_freq_select.sv
module ballast_freq_select
  import ballast_pkg::*;
#(
  parameter int CODE_W       = 6,
  parameter int TW           = 6,
  parameter int START_CYCLES = 4,
  parameter int RAMP_DIV     = 2,
  parameter int CODE_START   = 48,
  parameter int CODE_PH      = 20,
  parameter int CODE_MIN     = 17,
  parameter int CODE_RUN     = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mode_t             mode_i,
  input  logic [TW-1:0]     tmr_i,
  input  logic              tick_i,
  input  logic              strap_i,
  output logic [1:0]        fsel_o,
  output logic [CODE_W-1:0] fcode_o
);

  localparam int DW = (RAMP_DIV > 1) ? $clog2(RAMP_DIV) : 1;

  logic [CODE_W-1:0] ramp_q, ramp_d;
  logic [DW-1:0]     div_q, div_d;
  logic              ramp_act, ramp_en;
  fsel_t             fsel;

  assign ramp_act = (mode_i == MD_IGNITE);
  assign ramp_en  = !ramp_act || tick_i;

  always_comb begin
    ramp_d = ramp_q;
    div_d  = div_q;
    if (!ramp_act) begin
      ramp_d = CODE_W'(CODE_PH);
      div_d  = '0;
    end else if (div_q == DW'(RAMP_DIV - 1)) begin
      div_d = '0;
      if (ramp_q > CODE_W'(CODE_MIN)) ramp_d = ramp_q - CODE_W'(1);
    end else begin
      div_d = div_q + DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ramp_q <= CODE_W'(CODE_PH);
      div_q  <= '0;
    end else if (ramp_en) begin
      ramp_q <= ramp_d;
      div_q  <= div_d;
    end
  end

  always_comb begin
    fsel    = FS_START;
    fcode_o = CODE_W'(CODE_START);
    unique case (mode_i)
      MD_PREHEAT: if (tmr_i >= TW'(START_CYCLES)) begin
        fsel    = FS_PREHEAT;
        fcode_o = CODE_W'(CODE_PH);
      end
      MD_IGNITE: begin
        fsel    = FS_IGNITE;
        fcode_o = ramp_q;
      end
      MD_RUN: begin
        fsel    = strap_i ? FS_RUN : FS_IGNITE;
        fcode_o = strap_i ? CODE_W'(CODE_RUN) : CODE_W'(CODE_MIN);
      end
      default: ;
    endcase
  end

  assign fsel_o = fsel;

  AST_RAMP_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_act |-> (ramp_q >= CODE_W'(CODE_MIN)));  // R10
  AST_RAMP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_act && $past(ramp_act)) |->
      ((ramp_q == $past(ramp_q)) || (ramp_q == CODE_W'($past(ramp_q) - CODE_W'(1)))));  // R10

endmodule

// File: rtl/ballast_sequencer.sv
module ballast_sequencer
  import ballast_pkg::*;
#(
  parameter int PH_COUNT     = 40,
  parameter int START_CYCLES = 4,
  parameter int RAMP_DIV     = 2,
  parameter int CODE_W       = 6,
  parameter int CODE_START   = 48,
  parameter int CODE_PH      = 20,
  parameter int CODE_MIN     = 17,
  parameter int CODE_RUN     = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vcc_on_i,
  input  logic              vcc_off_i,
  input  logic              bus_ok_i,
  input  logic              sd_hi_i,
  input  logic              otemp_i,
  input  logic              ocur_i,
  input  logic              ucur_i,
  input  logic              osc_tick_i,
  input  logic              run_strap_i,
  output logic [2:0]        mode_o,
  output logic              bridge_en_o,
  output logic              oc_chk_en_o,
  output logic              uc_chk_en_o,
  output logic [1:0]        fsel_o,
  output logic [CODE_W-1:0] fcode_o
);

  localparam int IGN_END = PH_COUNT + PH_COUNT / 4;
  localparam int TW      = $clog2(IGN_END + 1);

  // Reset: asserted at once, released on the clock.
  logic [1:0] rst_pipe_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  // Comparator flags.
  logic [FLAG_N-1:0] flag_raw, flag_s;
  assign flag_raw[FL_VCC_ON]  = vcc_on_i;
  assign flag_raw[FL_VCC_OFF] = vcc_off_i;
  assign flag_raw[FL_BUS_OK]  = bus_ok_i;
  assign flag_raw[FL_SD]      = sd_hi_i;
  assign flag_raw[FL_OTEMP]   = otemp_i;
  assign flag_raw[FL_OCUR]    = ocur_i;
  assign flag_raw[FL_UCUR]    = ucur_i;

  ballast_flag_sync #(.WIDTH(FLAG_N), .RST_VAL(FLAG_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .d_i   (flag_raw),
    .q_o   (flag_s)
  );

  logic f_on, f_off, f_bus, f_sd, f_ot, f_oc, f_uc;
  assign f_on  = flag_s[FL_VCC_ON];
  assign f_off = flag_s[FL_VCC_OFF];
  assign f_bus = flag_s[FL_BUS_OK];
  assign f_sd  = flag_s[FL_SD];
  assign f_ot  = flag_s[FL_OTEMP];
  assign f_oc  = flag_s[FL_OCUR];
  assign f_uc  = flag_s[FL_UCUR];

  // Mode state.
  mode_t         mode_q, mode_d;
  logic          arm_q, arm_d;
  logic [TW-1:0] tmr;
  logic          active, oc_en, uc_en, drop, trip;

  assign active = is_active(mode_q);
  assign oc_en  = (mode_q == MD_IGNITE) || (mode_q == MD_RUN);
  assign uc_en  = (mode_q == MD_RUN);
  assign drop   = f_off || !f_bus || f_sd;
  assign trip   = f_ot || (oc_en && f_oc) || (uc_en && f_uc);

  always_comb begin
    mode_d = mode_q;
    arm_d  = 1'b0;
    unique case (mode_q)
      MD_UVLO: begin
        if (f_on && f_bus && !f_sd && !f_ot) mode_d = MD_PREHEAT;
      end
      MD_PREHEAT, MD_IGNITE, MD_RUN: begin
        if (drop)                                               mode_d = MD_UVLO;
        else if (trip)                                          mode_d = MD_FAULT;
        else if ((mode_q == MD_PREHEAT) && (tmr == TW'(PH_COUNT))) mode_d = MD_IGNITE;
        else if ((mode_q == MD_IGNITE) && (tmr == TW'(IGN_END)))   mode_d = MD_RUN;
      end
      MD_FAULT: begin
        arm_d = arm_q || f_sd;
        if (f_off || (arm_q && !f_sd)) begin
          mode_d = MD_UVLO;
          arm_d  = 1'b0;
        end
      end
      default: mode_d = MD_UVLO;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      mode_q <= MD_UVLO;
      arm_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      arm_q  <= arm_d;
    end
  end

  ballast_phase_timer #(.LIMIT(IGN_END), .W(TW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .clr_i  (!active),
    .run_i  ((mode_q == MD_PREHEAT) || (mode_q == MD_IGNITE)),
    .tick_i (osc_tick_i),
    .cnt_o  (tmr)
  );

  ballast_freq_select #(
    .CODE_W       (CODE_W),
    .TW           (TW),
    .START_CYCLES (START_CYCLES),
    .RAMP_DIV     (RAMP_DIV),
    .CODE_START   (CODE_START),
    .CODE_PH      (CODE_PH),
    .CODE_MIN     (CODE_MIN),
    .CODE_RUN     (CODE_RUN)
  ) u_freq (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .mode_i  (mode_q),
    .tmr_i   (tmr),
    .tick_i  (osc_tick_i),
    .strap_i (run_strap_i),
    .fsel_o  (fsel_o),
    .fcode_o (fcode_o)
  );

  assign mode_o      = mode_q;
  assign bridge_en_o = active;
  assign oc_chk_en_o = oc_en;
  assign uc_chk_en_o = uc_en;

  AST_ENTER_PREHEAT: assert property (@(posedge clk) disable iff (!rst_n_s)
    ((mode_q == MD_PREHEAT) && ($past(mode_q) != MD_PREHEAT)) |-> ($past(mode_q) == MD_UVLO));  // R2
  AST_ENTER_IGNITE: assert property (@(posedge clk) disable iff (!rst_n_s)
    ((mode_q == MD_IGNITE) && ($past(mode_q) != MD_IGNITE)) |-> ($past(mode_q) == MD_PREHEAT));  // R4
  AST_ENTER_RUN: assert property (@(posedge clk) disable iff (!rst_n_s)
    ((mode_q == MD_RUN) && ($past(mode_q) != MD_RUN)) |-> ($past(mode_q) == MD_IGNITE));  // R4
  AST_FAULT_EXIT: assert property (@(posedge clk) disable iff (!rst_n_s)
    (($past(mode_q) == MD_FAULT) && (mode_q != MD_FAULT)) |-> (mode_q == MD_UVLO));  // R8
  AST_PREHEAT_TIMER_FRESH: assert property (@(posedge clk) disable iff (!rst_n_s)
    ((mode_q == MD_PREHEAT) && ($past(mode_q) == MD_UVLO)) |-> (tmr == '0));  // R7

endmodule

// File: tb/ballast_sequencer_test.sv
module ballast_sequencer_test;

  localparam int CW = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic vcc_on, vcc_off, bus_ok, sd_hi, otemp, ocur, ucur, tick, strap;
  logic [2:0]    mode;
  logic          bridge, oc_en, uc_en;
  logic [1:0]    fsel;
  logic [CW-1:0] fcode;

  always #5 clk = ~clk;

  ballast_sequencer #(
    .PH_COUNT(40), .START_CYCLES(4), .RAMP_DIV(2), .CODE_W(CW),
    .CODE_START(48), .CODE_PH(20), .CODE_MIN(17), .CODE_RUN(26)
  ) uut (
    .clk(clk), .rst_n(rst_n), .vcc_on_i(vcc_on), .vcc_off_i(vcc_off),
    .bus_ok_i(bus_ok), .sd_hi_i(sd_hi), .otemp_i(otemp), .ocur_i(ocur),
    .ucur_i(ucur), .osc_tick_i(tick), .run_strap_i(strap),
    .mode_o(mode), .bridge_en_o(bridge), .oc_chk_en_o(oc_en),
    .uc_chk_en_o(uc_en), .fsel_o(fsel), .fcode_o(fcode)
  );

  typedef struct {
    logic [2:0]    mode;
    logic          bridge;
    logic          oc;
    logic          uc;
    logic [1:0]    fsel;
    logic [CW-1:0] fcode;
    string         tag;
  } exp_t;

  exp_t sb_q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 1'b0;

  // Driver side: push an expectation for the current sample point.
  task automatic expect_out(input logic [2:0] m, input logic b, input logic o,
                            input logic u, input logic [1:0] fs,
                            input logic [CW-1:0] fc, input string tag);
    exp_t e;
    e.mode = m; e.bridge = b; e.oc = o; e.uc = u; e.fsel = fs; e.fcode = fc; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic exp_idle(input logic [2:0] m, input string tag);
    expect_out(m, 1'b0, 1'b0, 1'b0, 2'd0, CW'(48), tag);
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor side: compare just after each falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_tests++;
        if (mode !== e.mode || bridge !== e.bridge || oc_en !== e.oc ||
            uc_en !== e.uc || fsel !== e.fsel || fcode !== e.fcode) begin
          n_fail++;
          $display("FAIL %s: actual mode=%0d br=%0b oc=%0b uc=%0b fsel=%0d code=%0d expected mode=%0d br=%0b oc=%0b uc=%0b fsel=%0d code=%0d",
                   e.tag, mode, bridge, oc_en, uc_en, fsel, fcode,
                   e.mode, e.bridge, e.oc, e.uc, e.fsel, e.fcode);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL R4 watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; vcc_on = 1'b0; vcc_off = 1'b1; bus_ok = 1'b0; sd_hi = 1'b0;
    otemp = 1'b0; ocur = 1'b0; ucur = 1'b0; tick = 1'b1; strap = 1'b1;
    wait_neg(3);
    rst_n = 1'b1;
    wait_neg(5);
    exp_idle(3'd0, "R1 reset state");

    // R2: each missing condition holds the block idle.
    vcc_on = 1'b1; vcc_off = 1'b0; bus_ok = 1'b1; sd_hi = 1'b1;
    wait_neg(6);
    exp_idle(3'd0, "R2 shutdown high blocks start");
    sd_hi = 1'b0; otemp = 1'b1;
    wait_neg(6);
    exp_idle(3'd0, "R2 overtemperature blocks start");
    otemp = 1'b0;
    wait_neg(2);
    exp_idle(3'd0, "R12 no change before third edge");
    wait_neg(1);
    expect_out(3'd1, 1'b1, 1'b0, 1'b0, 2'd0, CW'(48), "R12 start on third edge");  // k=0

    wait_neg(3);
    expect_out(3'd1, 1'b1, 1'b0, 1'b0, 2'd0, CW'(48), "R9 start phase");           // k=3
    wait_neg(1);
    expect_out(3'd1, 1'b1, 1'b0, 1'b0, 2'd1, CW'(20), "R9 preheat code");          // k=4
    ocur = 1'b1; ucur = 1'b1;
    wait_neg(10);
    expect_out(3'd1, 1'b1, 1'b0, 1'b0, 2'd1, CW'(20), "R5 current flags masked in preheat");  // k=14
    ocur = 1'b0; ucur = 1'b0;
    wait_neg(26);
    expect_out(3'd1, 1'b1, 1'b0, 1'b0, 2'd1, CW'(20), "R4 last preheat cycle");    // k=40
    wait_neg(1);
    expect_out(3'd2, 1'b1, 1'b1, 1'b0, 2'd2, CW'(20), "R4 R5 ignition entry");     // k=41
    wait_neg(3);
    expect_out(3'd2, 1'b1, 1'b1, 1'b0, 2'd2, CW'(19), "R10 ramp step");            // k=44
    wait_neg(6);
    expect_out(3'd2, 1'b1, 1'b1, 1'b0, 2'd2, CW'(17), "R10 ramp floor");           // k=50
    wait_neg(1);
    expect_out(3'd3, 1'b1, 1'b1, 1'b1, 2'd3, CW'(26), "R4 R11 run with strap");    // k=51

    // R6/R8: under-current fault, latch, shutdown pulse release.
    ucur = 1'b1;
    wait_neg(3);
    exp_idle(3'd4, "R6 R7 under-current in run");
    ucur = 1'b0;
    wait_neg(8);
    exp_idle(3'd4, "R8 latched after cause removed");
    sd_hi = 1'b1;
    wait_neg(6);
    exp_idle(3'd4, "R8 shutdown high alone keeps fault");
    sd_hi = 1'b0;
    wait_neg(3);
    exp_idle(3'd0, "R8 shutdown pulse clears fault");
    wait_neg(1);
    expect_out(3'd1, 1'b1, 1'b0, 1'b0, 2'd0, CW'(48), "R7 restart from zero timer");

    // R3: bus low during preheat.
    wait_neg(5);
    bus_ok = 1'b0;
    wait_neg(3);
    exp_idle(3'd0, "R3 bus low");
    bus_ok = 1'b1; strap = 1'b0;
    wait_neg(3);
    expect_out(3'd1, 1'b1, 1'b0, 1'b0, 2'd0, CW'(48), "R2 resume after bus");     // k=0

    // R6: over-current in ignition; R8 supply release.
    wait_neg(41);
    expect_out(3'd2, 1'b1, 1'b1, 1'b0, 2'd2, CW'(20), "R4 ignition again");
    ocur = 1'b1;
    wait_neg(3);
    exp_idle(3'd4, "R6 over-current in ignition");
    ocur = 1'b0; vcc_on = 1'b0; vcc_off = 1'b1;
    wait_neg(3);
    exp_idle(3'd0, "R8 supply low clears fault");
    vcc_on = 1'b1; vcc_off = 1'b0;
    wait_neg(3);
    expect_out(3'd1, 1'b1, 1'b0, 1'b0, 2'd0, CW'(48), "R2 restart after supply"); // k=0

    // R11 strap clear; R6 overtemperature.
    wait_neg(51);
    expect_out(3'd3, 1'b1, 1'b1, 1'b1, 2'd2, CW'(17), "R11 run with strap clear");
    otemp = 1'b1;
    wait_neg(3);
    exp_idle(3'd4, "R6 overtemperature in run");
    otemp = 1'b0; vcc_on = 1'b0; vcc_off = 1'b1;
    wait_neg(3);
    exp_idle(3'd0, "R8 supply release");
    vcc_on = 1'b1; vcc_off = 1'b0;
    wait_neg(3);
    expect_out(3'd1, 1'b1, 1'b0, 1'b0, 2'd0, CW'(48), "R2 restart");              // k=0

    // R3 priority: shutdown and over-current together in run.
    wait_neg(51);
    expect_out(3'd3, 1'b1, 1'b1, 1'b1, 2'd2, CW'(17), "R4 run reached");
    sd_hi = 1'b1; ocur = 1'b1;
    wait_neg(3);
    exp_idle(3'd0, "R3 shutdown wins over over-current");
    sd_hi = 1'b0; ocur = 1'b0;
    wait_neg(3);
    expect_out(3'd1, 1'b1, 1'b0, 1'b0, 2'd0, CW'(48), "R2 restart after lamp change");
    vcc_off = 1'b1;
    wait_neg(3);
    exp_idle(3'd0, "R3 supply below turn-off");

    wait_neg(3);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule